// File: doc/BRIEF.md
# Early Receive Status Tracker

This block watches a network receive path while a frame is still streaming in and keeps a byte-wide status value with four live flags: early threshold crossed, frame completed good, frame completed bad, and receive ring overwrite. A per-frame byte counter is restarted by a frame-start strobe and advanced by a byte-valid strobe. Once the count rises above a programmable threshold, the early flag is raised and a one-cycle receive-OK interrupt request is issued. This lets software begin draining a frame before the frame has fully landed.

When the frame-done strobe arrives, the block records a good or bad completion and drops the early flag. In that same cycle it pulses the matching completion line toward the main interrupt status logic. A separate watcher raises the overwrite flag whenever the hardware write pointer of the receive ring is updated onto the software read pointer. This happens, for example, when the hardware rewinds to the start of a failed frame to write the next one. Software clears any flag by writing a one to its bit. Writing zero leaves a bit alone.

Top module: `erx_status_top`

## Requirements
- R1: After synchronous reset, `status` reads 8'h00 and `rok_irq`, `cmpl_ok` and `cmpl_err` are all 0.
- R2: Bits 7..4 of `status` always read 0, including after a write of 8'hF0.
- R3: A `frm_done` strobe with `frm_good`=1 sets bit 3 (good-complete) and produces a single-cycle `cmpl_ok` pulse, both visible one clock after the strobe.
- R4: A `frm_done` strobe with `frm_good`=0 sets bit 2 (bad-complete) and produces a single-cycle `cmpl_err` pulse, both visible one clock after the strobe.
- R5: Bit 0 (early-OK) sets one clock after the byte that makes the frame's byte count strictly greater than `rx_thresh`. A count equal to the threshold does not set it.
- R6: `rok_irq` pulses high for exactly one cycle, in the cycle in which bit 0 goes from 0 to 1.
- R7: Bit 0 sets at most once per frame, even after software clears it mid-frame. `frm_start` restarts the byte count at zero and re-arms the early detection.
- R8: The cycle in which `cmpl_ok` or `cmpl_err` is high has bit 0 at 0.
- R9: Bit 1 (overwrite) sets one clock after a `ptr_upd` strobe whose `hw_wptr` equals `sw_rptr`. An update to a different value does not set it.
- R10: A `csr_wr` with a 1 in any of bits 3..0 of `csr_wdata` clears that flag. A 0 in a bit leaves that flag unchanged.
- R11: When a hardware set event and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_start | input | 1 | Start of a new frame; restarts the byte count |
| byte_vld | input | 1 | One received byte of the current frame |
| rx_thresh | input | 16 | Early threshold in bytes |
| frm_done | input | 1 | Frame completely received |
| frm_good | input | 1 | Qualifies `frm_done`: 1 = no error, 0 = error |
| ptr_upd | input | 1 | Hardware ring write pointer updated this cycle |
| hw_wptr | input | 16 | Hardware ring write pointer |
| sw_rptr | input | 16 | Software ring read pointer |
| csr_wr | input | 1 | Status write strobe |
| csr_wdata | input | 8 | Write data; a 1 clears the flag at that bit |
| status | output | 8 | {4'b0, good, bad, overwrite, early-OK} |
| rok_irq | output | 1 | Receive-OK interrupt request pulse |
| cmpl_ok | output | 1 | Good-completion pulse to interrupt status logic |
| cmpl_err | output | 1 | Error-completion pulse to interrupt status logic |

## Verification
The threshold compare is driven with byte runs that stop exactly at the threshold and then one past it. This separates a strictly-greater compare from a greater-or-equal compare. A frame whose early flag is cleared mid-frame and then given more bytes shows whether detection is once per frame, and a second frame shows that the count really restarts. The pointer watcher gets updates both to a mismatched value and to the read pointer, which separates the equality check from a plain update strobe. Writes of zero, of the reserved nibble, and of one-bits that coincide with a completion separate write-one-to-clear and set priority from ordinary register writes.

// File: rtl/erx_pkg.sv
package erx_pkg;
    localparam int STAT_W   = 8;
    localparam int FLAG_N   = 4;
    localparam int B_EARLY  = 0;
    localparam int B_OVW    = 1;
    localparam int B_BAD    = 2;
    localparam int B_GOOD   = 3;

    // Flag set ordered so that the packed layout matches status bits 3..0.
    typedef struct packed {
        logic good;
        logic bad;
        logic ovw;
        logic early;
    } erx_flags_t;

    // Hardware events that can set a flag in a given cycle.
    typedef struct packed {
        logic done;
        logic good;
        logic early;
        logic ovw;
    } erx_evt_t;

    function automatic erx_flags_t clr_mask(input logic wr, input logic [FLAG_N-1:0] d);
        erx_flags_t m;
        m = wr ? erx_flags_t'(d) : erx_flags_t'('0);
        return m;
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(input erx_flags_t f);
        logic [STAT_W-1:0] s;
        s = '0;
        s[FLAG_N-1:0] = f;
        return s;
    endfunction
endpackage

// File: rtl/erx_byte_tracker.sv
module erx_byte_tracker #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frm_start,
    input  logic             byte_vld,
    input  logic             frm_done,
    input  logic [CNT_W-1:0] rx_thresh,
    output logic             early_evt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q, cnt_base, cnt_n;
    logic             active_q, fired_q;
    logic             fired_eff, active_eff;

    always_comb begin
        cnt_base   = frm_start ? '0 : cnt_q;
        fired_eff  = frm_start ? 1'b0 : fired_q;
        active_eff = frm_start | active_q;
        if (byte_vld && cnt_base != CNT_MAX)
            cnt_n = cnt_base + 1'b1;
        else
            cnt_n = cnt_base;
        early_evt = active_eff & ~fired_eff & ~frm_done & (cnt_n > rx_thresh);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
            fired_q  <= 1'b0;
        end else begin
            cnt_q    <= cnt_n;
            active_q <= active_eff & ~frm_done;
            fired_q  <= fired_eff | early_evt;
        end
    end
endmodule

// File: rtl/erx_ring_watch.sv
module erx_ring_watch #(
    parameter int PTR_W = 16
) (
    input  logic             ptr_upd,
    input  logic [PTR_W-1:0] hw_wptr,
    input  logic [PTR_W-1:0] sw_rptr,
    output logic             ovw_evt
);
    always_comb ovw_evt = ptr_upd && (hw_wptr == sw_rptr);
endmodule

// File: rtl/erx_status_reg.sv
module erx_status_reg
    import erx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  erx_evt_t          evt,
    input  logic              csr_wr,
    input  logic [FLAG_N-1:0] csr_wdata,
    output logic [STAT_W-1:0] status,
    output logic              rok_irq,
    output logic              cmpl_ok,
    output logic              cmpl_err
);
    erx_flags_t flags_q, flags_n, clr;

    always_comb begin
        clr = clr_mask(csr_wr, csr_wdata);
        flags_n.good = (evt.done & evt.good)  | (flags_q.good & ~clr.good);
        flags_n.bad  = (evt.done & ~evt.good) | (flags_q.bad  & ~clr.bad);
        flags_n.ovw  = evt.ovw                | (flags_q.ovw  & ~clr.ovw);
        if (evt.early)
            flags_n.early = 1'b1;
        else if (evt.done)
            flags_n.early = 1'b0;
        else
            flags_n.early = flags_q.early & ~clr.early;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q  <= '0;
            rok_irq  <= 1'b0;
            cmpl_ok  <= 1'b0;
            cmpl_err <= 1'b0;
        end else begin
            flags_q  <= flags_n;
            rok_irq  <= evt.early & ~flags_q.early;
            cmpl_ok  <= evt.done & evt.good;
            cmpl_err <= evt.done & ~evt.good;
        end
    end

    always_comb status = pack_status(flags_q);
endmodule

// File: rtl/erx_status_top.sv
module erx_status_top
    import erx_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PTR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_start,
    input  logic              byte_vld,
    input  logic [CNT_W-1:0]  rx_thresh,
    input  logic              frm_done,
    input  logic              frm_good,
    input  logic              ptr_upd,
    input  logic [PTR_W-1:0]  hw_wptr,
    input  logic [PTR_W-1:0]  sw_rptr,
    input  logic              csr_wr,
    input  logic [STAT_W-1:0] csr_wdata,
    output logic [STAT_W-1:0] status,
    output logic              rok_irq,
    output logic              cmpl_ok,
    output logic              cmpl_err
);
    logic     early_evt, ovw_evt;
    erx_evt_t evt;
    logic     unused_hi;

    assign unused_hi = ^csr_wdata[STAT_W-1:FLAG_N];

    erx_byte_tracker #(.CNT_W(CNT_W)) trk_i (
        .clk(clk), .rst(rst), .frm_start(frm_start), .byte_vld(byte_vld),
        .frm_done(frm_done), .rx_thresh(rx_thresh), .early_evt(early_evt)
    );

    erx_ring_watch #(.PTR_W(PTR_W)) ring_i (
        .ptr_upd(ptr_upd), .hw_wptr(hw_wptr), .sw_rptr(sw_rptr), .ovw_evt(ovw_evt)
    );

    always_comb begin
        evt.done  = frm_done;
        evt.good  = frm_good;
        evt.early = early_evt;
        evt.ovw   = ovw_evt;
    end

    erx_status_reg reg_i (
        .clk(clk), .rst(rst), .evt(evt), .csr_wr(csr_wr),
        .csr_wdata(csr_wdata[FLAG_N-1:0]), .status(status),
        .rok_irq(rok_irq), .cmpl_ok(cmpl_ok), .cmpl_err(cmpl_err)
    );
endmodule

// File: rtl/erx_status_chk.sv
module erx_status_chk #(
    parameter int PTR_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             frm_done,
    input logic             frm_good,
    input logic             ptr_upd,
    input logic [PTR_W-1:0] hw_wptr,
    input logic [PTR_W-1:0] sw_rptr,
    input logic             csr_wr,
    input logic [7:0]       csr_wdata,
    input logic [7:0]       status,
    input logic             rok_irq,
    input logic             cmpl_ok,
    input logic             cmpl_err
);
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst) status[7:4] == 4'h0);
    p_good_sets_r3: assert property (@(posedge clk) disable iff (rst)
        (frm_done && frm_good) |=> (status[3] && cmpl_ok));
    p_bad_sets_r4: assert property (@(posedge clk) disable iff (rst)
        (frm_done && !frm_good) |=> (status[2] && cmpl_err));
    p_cmpl_excl_r3: assert property (@(posedge clk) disable iff (rst) !(cmpl_ok && cmpl_err));
    p_rok_rise_r6: assert property (@(posedge clk) disable iff (rst)
        rok_irq |-> (status[0] && !$past(status[0])));
    p_rok_single_r6: assert property (@(posedge clk) disable iff (rst) rok_irq |=> !rok_irq);
    p_done_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (cmpl_ok || cmpl_err) |-> !status[0]);
    p_ovw_sets_r9: assert property (@(posedge clk) disable iff (rst)
        (ptr_upd && hw_wptr == sw_rptr) |=> status[1]);
    p_zero_keeps_r10: assert property (@(posedge clk) disable iff (rst)
        (csr_wr && !csr_wdata[3] && status[3]) |=> status[3]);
    p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
        (frm_done && frm_good && csr_wr && csr_wdata[3]) |=> status[3]);
endmodule

bind erx_status_top erx_status_chk #(.PTR_W(PTR_W)) chk_i (
    .clk(clk), .rst(rst), .frm_done(frm_done), .frm_good(frm_good),
    .ptr_upd(ptr_upd), .hw_wptr(hw_wptr), .sw_rptr(sw_rptr),
    .csr_wr(csr_wr), .csr_wdata(csr_wdata), .status(status),
    .rok_irq(rok_irq), .cmpl_ok(cmpl_ok), .cmpl_err(cmpl_err)
);

// File: tb/erx_status_top_tb.sv
module erx_status_top_tb_top;
    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        frm_start, byte_vld, frm_done, frm_good, ptr_upd, csr_wr;
    logic [15:0] rx_thresh, hw_wptr, sw_rptr;
    logic [7:0]  csr_wdata, status;
    logic        rok_irq, cmpl_ok, cmpl_err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    erx_status_top dut_i (
        .clk(clk), .rst(rst), .frm_start(frm_start), .byte_vld(byte_vld),
        .rx_thresh(rx_thresh), .frm_done(frm_done), .frm_good(frm_good),
        .ptr_upd(ptr_upd), .hw_wptr(hw_wptr), .sw_rptr(sw_rptr),
        .csr_wr(csr_wr), .csr_wdata(csr_wdata), .status(status),
        .rok_irq(rok_irq), .cmpl_ok(cmpl_ok), .cmpl_err(cmpl_err)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic idle();
        frm_start = 0; byte_vld = 0; frm_done = 0; frm_good = 0;
        ptr_upd = 0; csr_wr = 0; csr_wdata = 8'h00;
    endtask

    task automatic wr(input logic [7:0] d);
        csr_wr = 1; csr_wdata = d; cyc(); csr_wr = 0; csr_wdata = 8'h00;
    endtask

    task automatic bytes(input int n);
        for (int i = 0; i < n; i++) begin byte_vld = 1; cyc(); end
        byte_vld = 0;
    endtask

    task automatic start_frame();
        frm_start = 1; cyc(); frm_start = 0;
    endtask

    task automatic finish_frame(input logic good);
        frm_done = 1; frm_good = good; cyc(); frm_done = 0; frm_good = 0;
    endtask

    task automatic t_reset();
        rst = 1; idle(); rx_thresh = 16'd4; hw_wptr = 0; sw_rptr = 0;
        cyc(); cyc(); rst = 0; cyc();
        chk("R1 status", status, 8'h00);
        chk("R1 pulses", {5'b0, rok_irq, cmpl_ok, cmpl_err}, 8'h00);
    endtask

    task automatic t_threshold();
        rx_thresh = 16'd4;
        start_frame();
        bytes(4);
        chk("R5 equal count no early", status, 8'h00);
        chk("R6 no irq at equal", {7'b0, rok_irq}, 8'h00);
        bytes(1);
        chk("R5 early set past threshold", status, 8'h01);
        chk("R6 irq on rise", {7'b0, rok_irq}, 8'h01);
        cyc();
        chk("R6 irq single cycle", {7'b0, rok_irq}, 8'h00);
        chk("R5 early holds", status, 8'h01);
        finish_frame(1'b1);
        chk("R8 early cleared at completion", status, 8'h08);
        chk("R3 cmpl_ok pulse", {6'b0, cmpl_ok, cmpl_err}, 8'h02);
        cyc();
        chk("R3 cmpl_ok single", {6'b0, cmpl_ok, cmpl_err}, 8'h00);
        wr(8'h08);
        chk("R10 good cleared by one", status, 8'h00);
    endtask

    task automatic t_bad_frame();
        rx_thresh = 16'd100;
        start_frame(); bytes(3);
        finish_frame(1'b0);
        chk("R4 bad flag", status, 8'h04);
        chk("R4 cmpl_err pulse", {6'b0, cmpl_ok, cmpl_err}, 8'h01);
        cyc();
        chk("R4 cmpl_err single", {6'b0, cmpl_ok, cmpl_err}, 8'h00);
        wr(8'h04);
        chk("R10 bad cleared", status, 8'h00);
    endtask

    task automatic t_once_per_frame();
        rx_thresh = 16'd2;
        start_frame(); bytes(3);
        chk("R7 first early", status, 8'h01);
        wr(8'h01);
        chk("R10 early cleared by one", status, 8'h00);
        bytes(3);
        chk("R7 no second early in frame", status, 8'h00);
        chk("R7 no second irq", {7'b0, rok_irq}, 8'h00);
        start_frame(); bytes(2);
        chk("R7 count restarted", status, 8'h00);
        bytes(1);
        chk("R7 early rearmed", status, 8'h01);
        finish_frame(1'b0);
        chk("R8 early cleared on error done", status, 8'h04);
        wr(8'h0F);
        chk("R10 all cleared", status, 8'h00);
    endtask

    task automatic t_overwrite();
        sw_rptr = 16'h0010; hw_wptr = 16'h000F; ptr_upd = 1; cyc(); ptr_upd = 0;
        chk("R9 mismatch no set", status, 8'h00);
        hw_wptr = 16'h0010; cyc();
        chk("R9 equal without update no set", status, 8'h00);
        ptr_upd = 1; cyc(); ptr_upd = 0;
        chk("R9 overwrite set", status, 8'h02);
        hw_wptr = 16'h0020;
    endtask

    task automatic t_writes();
        finish_frame(1'b1);
        chk("R3 good with overwrite", status, 8'h0A);
        wr(8'h00);
        chk("R10 zero write no effect", status, 8'h0A);
        wr(8'hF0);
        chk("R2 reserved read zero", status, 8'h0A);
        wr(8'h02);
        chk("R10 overwrite cleared only", status, 8'h08);
        frm_done = 1; frm_good = 1; csr_wr = 1; csr_wdata = 8'h08; cyc();
        idle();
        chk("R11 set beats clear", status, 8'h08);
        sw_rptr = 16'h0030; hw_wptr = 16'h0030; ptr_upd = 1;
        csr_wr = 1; csr_wdata = 8'h0A; cyc();
        idle();
        chk("R11 overwrite set beats clear, good cleared", status, 8'h02);
        wr(8'h02);
        chk("R10 final clear", status, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_threshold();
        t_bad_frame();
        t_once_per_frame();
        t_overwrite();
        t_writes();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule